// File: doc/BRIEF.md
# Flash Programming Mode Sequencer

This block is the device-side controller that lets an external programmer load an on-chip code flash over a parallel pin interface. A three-bit mode pin field selects the operation. The programmer drives an address and a data byte. An active-low program strobe, qualified by a high-voltage enable input, then starts a self-timed operation. That operation is a byte write, a lock-bit write or a chip erase. The flash array is a behavioural register array, and every operation time is a parameter counted in clock cycles.

While an operation runs, the ready/busy output is low. A verify read of the byte being written returns that byte with bit 7 inverted, so a programmer can poll either the pin or the data. Several rules are enforced. A byte that is not blank cannot be rewritten until the array is erased. The lock bits, once set, block code readback. The signature mode returns fixed identification bytes whatever the lock state.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted and after it is released, `readyBusy` is 1, every array byte reads FFH in verify mode and both lock bits are clear.
- R2: In write mode (`pinMode`=1) with `hvEn`=1, a rising edge of `progN` on a blank byte (FFH) starts a write. The write latches `addr` and `dataIn`. `readyBusy` is low for exactly WRITE_CYC cycles, starting the cycle after the edge is sampled. Afterwards the byte reads back as the written value.
- R3: While a byte write is in progress, a verify read (`pinMode`=2) at the address being written returns the written data with bit 7 inverted. Once `readyBusy` returns high, the true data is returned.
- R4: A program strobe with `hvEn`=0 starts no operation and changes no stored byte.
- R5: A program strobe that arrives while `readyBusy` is low is ignored, and the byte it addresses stays unchanged.
- R6: A write aimed at a byte that is not FFH is rejected. `readyBusy` stays high and the stored value is unchanged.
- R7: In erase mode (`pinMode`=5) with `hvEn`=1, holding `progN` low for ERASE_MIN consecutive cycles starts a chip erase. `readyBusy` is low for ERASE_CYC cycles, then every byte reads FFH and both lock bits are clear. A shorter low pulse has no effect.
- R8: In signature mode (`pinMode`=6), address 30H returns 1EH, 31H returns 51H and 32H returns FFH (SIG_HV=1) or 05H (SIG_HV=0). Any other address returns 00H. Signature reads are unaffected by the lock bits.
- R9: A program strobe with `hvEn`=1 in lock-1 mode (`pinMode`=3) or lock-2 mode (`pinMode`=4) holds `readyBusy` low for WRITE_CYC cycles and then sets that lock bit. While either lock bit is set, verify reads return 00H.
- R10: In any mode other than verify or signature, `dataOut` is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinMode | input | 3 | Operation select: 0 idle, 1 write, 2 verify, 3 lock-1, 4 lock-2, 5 erase, 6 signature |
| hvEn | input | 1 | High-voltage programming enable |
| progN | input | 1 | Active-low program strobe |
| addr | input | AW | Byte address |
| dataIn | input | 8 | Byte to write |
| dataOut | output | 8 | Readback byte |
| readyBusy | output | 1 | 1 ready, 0 busy |

## Verification
A wrong busy counter shows up as an incorrect low time on `readyBusy`. The bench measures that low time cycle by cycle for every write and erase, so a miscount is caught on the operation where it first appears. A lost or wrong blank check shows on the next readback of the affected byte. The bench checks that readback immediately after each random write, and also checks that a rejected write leaves `readyBusy` high. Lock-bit or erase-state faults appear as verify data that differs from the bench model on the read that follows the lock or erase operation.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_WRITE  = 3'd1,
    MODE_VERIFY = 3'd2,
    MODE_LOCK1  = 3'd3,
    MODE_LOCK2  = 3'd4,
    MODE_ERASE  = 3'd5,
    MODE_SIG    = 3'd6,
    MODE_SPARE  = 3'd7
  } fpsMode_t;

  typedef enum logic [1:0] {
    OP_BYTE  = 2'd0,
    OP_LOCK1 = 2'd1,
    OP_LOCK2 = 2'd2,
    OP_ERASE = 2'd3
  } fpsOp_t;

  typedef struct packed {
    logic startWr;
    logic commitByte;
    logic commitLock1;
    logic commitLock2;
    logic commitErase;
    logic pollActive;
  } fpsStrobe_t;
endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int WRITE_CYC = 18000,
  parameter int ERASE_CYC = 120000,
  parameter int ERASE_MIN = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  fpsMode_t   mode,
  input  logic       hvEn,
  input  logic       progN,
  input  logic       tgtBlank,
  output fpsStrobe_t strb,
  output logic       readyBusy
);
  localparam int MAXCYC = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int CW = $clog2(MAXCYC + 1);
  localparam int LW = $clog2(ERASE_MIN + 1);

  logic          progPrev;
  logic          busy;
  fpsOp_t        curOp;
  logic [CW-1:0] busyCnt;
  logic [LW-1:0] lowCnt;

  logic progRise, armByte, armLock, armErase, eraseHold, done;

  always_comb begin
    progRise  = progN && !progPrev;
    armByte   = progRise && hvEn && !busy && (mode == MODE_WRITE) && tgtBlank;
    armLock   = progRise && hvEn && !busy && ((mode == MODE_LOCK1) || (mode == MODE_LOCK2));
    eraseHold = (mode == MODE_ERASE) && hvEn && !progN;
    armErase  = eraseHold && !busy && (lowCnt == LW'(ERASE_MIN - 1));
    done      = busy && (busyCnt == CW'(1));
    strb.startWr     = armByte;
    strb.commitByte  = done && (curOp == OP_BYTE);
    strb.commitLock1 = done && (curOp == OP_LOCK1);
    strb.commitLock2 = done && (curOp == OP_LOCK2);
    strb.commitErase = done && (curOp == OP_ERASE);
    strb.pollActive  = busy && (curOp == OP_BYTE);
    readyBusy = !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPrev <= 1'b1;
      busy     <= 1'b0;
      curOp    <= OP_BYTE;
      busyCnt  <= '0;
      lowCnt   <= '0;
    end else begin
      progPrev <= progN;
      if (!eraseHold) lowCnt <= '0;
      else if (lowCnt != LW'(ERASE_MIN)) lowCnt <= lowCnt + 1'b1;
      if (armByte || armLock) begin
        busy    <= 1'b1;
        busyCnt <= CW'(WRITE_CYC);
        curOp   <= armByte ? OP_BYTE : ((mode == MODE_LOCK1) ? OP_LOCK1 : OP_LOCK2);
      end else if (armErase) begin
        busy    <= 1'b1;
        busyCnt <= CW'(ERASE_CYC);
        curOp   <= OP_ERASE;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
        if (done) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!rstN) a_r1_ready_in_reset: assert (readyBusy);
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWr |=> !readyBusy);

  a_r5_no_start_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    !readyBusy && progRise |=> $stable(curOp) || $past(done));

  a_r7_erase_after_low: assert property (@(posedge clk) disable iff (!rstN)
    armErase |-> !progN && (lowCnt != '0));
endmodule

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int AW     = 6,
  parameter bit SIG_HV = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fpsMode_t      mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dataIn,
  input  fpsStrobe_t    strb,
  output logic          tgtBlank,
  output logic [7:0]    dataOut
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] SIG_VOLT = SIG_HV ? 8'hFF : 8'h05;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrAddr;
  logic [7:0]    wrData;
  logic          lock1, lock2;

  assign tgtBlank = (mem[addr] == 8'hFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      wrAddr <= '0;
      wrData <= 8'hFF;
      lock1  <= 1'b0;
      lock2  <= 1'b0;
    end else begin
      if (strb.startWr) begin
        wrAddr <= addr;
        wrData <= dataIn;
      end
      if (strb.commitByte) mem[wrAddr] <= wrData;
      if (strb.commitLock1) lock1 <= 1'b1;
      if (strb.commitLock2) lock2 <= 1'b1;
      if (strb.commitErase) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        lock1 <= 1'b0;
        lock2 <= 1'b0;
      end
    end
  end

  always_comb begin
    dataOut = 8'h00;
    case (mode)
      MODE_VERIFY: begin
        if (strb.pollActive && (addr == wrAddr)) dataOut = {~wrData[7], wrData[6:0]};
        else if (lock1 || lock2) dataOut = 8'h00;
        else dataOut = mem[addr];
      end
      MODE_SIG: begin
        if (addr == AW'(8'h30)) dataOut = 8'h1E;
        else if (addr == AW'(8'h31)) dataOut = 8'h51;
        else if (addr == AW'(8'h32)) dataOut = SIG_VOLT;
      end
      default: dataOut = 8'h00;
    endcase
  end

  a_r3_poll_inverts: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollActive && (mode == MODE_VERIFY) && (addr == wrAddr) |-> dataOut[7] != wrData[7]);

  a_r6_commit_only_blank: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitByte |-> mem[wrAddr] == 8'hFF);

  a_r7_erase_fills: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commitErase) |-> (mem[0] == 8'hFF) && !lock1 && !lock2);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW        = 6,
  parameter int WRITE_CYC = 18000,
  parameter int ERASE_CYC = 120000,
  parameter int ERASE_MIN = 100000,
  parameter bit SIG_HV    = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    pinMode,
  input  logic          hvEn,
  input  logic          progN,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dataIn,
  output logic [7:0]    dataOut,
  output logic          readyBusy
);
  fpsMode_t   mode;
  fpsStrobe_t strb;
  logic       tgtBlank;

  assign mode = fpsMode_t'(pinMode);

  fps_ctrl #(
    .WRITE_CYC(WRITE_CYC),
    .ERASE_CYC(ERASE_CYC),
    .ERASE_MIN(ERASE_MIN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .hvEn(hvEn), .progN(progN),
    .tgtBlank(tgtBlank), .strb(strb), .readyBusy(readyBusy)
  );

  fps_datapath #(
    .AW(AW),
    .SIG_HV(SIG_HV)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .mode(mode), .addr(addr), .dataIn(dataIn),
    .strb(strb), .tgtBlank(tgtBlank), .dataOut(dataOut)
  );
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int WCYC = 20;
  localparam int ECYC = 30;
  localparam int EMIN = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    pinMode = 3'd0;
  logic          hvEn = 1'b0;
  logic          progN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = 8'h00;
  logic [7:0]    dataOut;
  logic          readyBusy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] mdlMem [DEPTH];
  bit mdlLock = 1'b0;

  always #2 clk = ~clk;

  flash_prog_seq #(.AW(AW), .WRITE_CYC(WCYC), .ERASE_CYC(ECYC), .ERASE_MIN(EMIN), .SIG_HV(1'b1))
    i_flash_prog_seq (.clk(clk), .rstN(rstN), .pinMode(pinMode), .hvEn(hvEn), .progN(progN),
                      .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .readyBusy(readyBusy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expVerify(input logic [AW-1:0] a);
    return mdlLock ? 8'h00 : mdlMem[a];
  endfunction

  function automatic logic [7:0] expSig(input logic [AW-1:0] a);
    case (a)
      6'h30: return 8'h1E;
      6'h31: return 8'h51;
      6'h32: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic readAt(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    pinMode = m;
    addr = a;
    #1 d = dataOut;
  endtask

  // strobe, then count busy cycles; kind 1: poll check, kind 2: extra strobe while busy
  task automatic strobeOp(input logic [2:0] m, input logic hv, input logic [AW-1:0] a,
                          input logic [7:0] d, input int kind, input logic [AW-1:0] a2,
                          output int busyCyc);
    int n;
    @(negedge clk);
    pinMode = m; hvEn = hv; addr = a; dataIn = d; progN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    progN = 1'b1;
    busyCyc = 0;
    n = 0;
    @(negedge clk);
    while ((readyBusy == 1'b0) && (n < 1000)) begin
      busyCyc++;
      if (kind == 1 && busyCyc == 3) begin
        pinMode = 3'd2;
        #1 chk("R3 poll read", dataOut, {~d[7], d[6:0]});
      end
      if (kind == 2 && busyCyc == 4) begin
        addr = a2; dataIn = ~d; progN = 1'b0;
      end
      if (kind == 2 && busyCyc == 5) progN = 1'b1;
      @(negedge clk);
      n++;
    end
    hvEn = 1'b0;
  endtask

  task automatic eraseOp(input int lowCyc, output int busyCyc);
    int n;
    @(negedge clk);
    pinMode = 3'd5; hvEn = 1'b1; progN = 1'b0;
    busyCyc = 0;
    for (int i = 0; i < lowCyc; i++) begin
      @(negedge clk);
      if (readyBusy == 1'b0) busyCyc++;
    end
    progN = 1'b1;
    n = 0;
    @(negedge clk);
    while ((readyBusy == 1'b0) && (n < 1000)) begin
      busyCyc++;
      @(negedge clk);
      n++;
    end
    hvEn = 1'b0;
    pinMode = 3'd0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int bc;
    int seedVal;
    seedVal = $urandom(32'h5EED);
    for (int i = 0; i < DEPTH; i++) mdlMem[i] = 8'hFF;

    #1 chk("R1 ready during reset", readyBusy, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", readyBusy, 1);
    readAt(3'd2, 6'd0, rd);  chk("R1 blank byte 0", rd, 8'hFF);
    readAt(3'd2, 6'd63, rd); chk("R1 blank byte 63", rd, 8'hFF);
    readAt(3'd0, 6'd0, rd);  chk("R10 idle output", rd, 8'h00);

    // directed write with polling
    strobeOp(3'd1, 1'b1, 6'd5, 8'h3C, 1, 6'd0, bc);
    chk("R2 busy length", bc, WCYC);
    mdlMem[5] = 8'h3C;
    readAt(3'd2, 6'd5, rd); chk("R3 true data after write", rd, 8'h3C);
    readAt(3'd1, 6'd5, rd); chk("R10 write mode output", rd, 8'h00);

    // strobe while busy
    strobeOp(3'd1, 1'b1, 6'd9, 8'hA5, 2, 6'd10, bc);
    mdlMem[9] = 8'hA5;
    chk("R5 busy length unchanged", bc, WCYC);
    readAt(3'd2, 6'd10, rd); chk("R5 ignored strobe target", rd, 8'hFF);
    readAt(3'd2, 6'd9, rd);  chk("R2 first write kept", rd, 8'hA5);

    // rejection of non-blank
    strobeOp(3'd1, 1'b1, 6'd5, 8'h00, 0, 6'd0, bc);
    chk("R6 no busy on non-blank", bc, 0);
    readAt(3'd2, 6'd5, rd); chk("R6 value unchanged", rd, 8'h3C);

    // no high voltage
    strobeOp(3'd1, 1'b0, 6'd20, 8'h11, 0, 6'd0, bc);
    chk("R4 no busy without hv", bc, 0);
    readAt(3'd2, 6'd20, rd); chk("R4 byte unchanged", rd, 8'hFF);

    // random writes
    for (int k = 0; k < 30; k++) begin
      logic [AW-1:0] ra;
      logic [7:0] rdat;
      logic rhv;
      ra = AW'($urandom_range(0, DEPTH - 1));
      rdat = 8'($urandom_range(0, 254));
      rhv = ($urandom_range(0, 5) != 0);
      strobeOp(3'd1, rhv, ra, rdat, ($urandom_range(0, 1) == 1) ? 1 : 0, 6'd0, bc);
      if (rhv && mdlMem[ra] == 8'hFF) begin
        chk("R2 random busy length", bc, WCYC);
        mdlMem[ra] = rdat;
      end else begin
        chk("R6 R4 random no busy", bc, 0);
      end
      readAt(3'd2, ra, rd); chk("R2 random readback", rd, expVerify(ra));
    end

    // short erase pulse
    eraseOp(EMIN - 1, bc);
    chk("R7 short pulse no busy", bc, 0);
    readAt(3'd2, 6'd5, rd); chk("R7 short pulse keeps data", rd, expVerify(6'd5));

    // lock 1
    strobeOp(3'd3, 1'b1, 6'd0, 8'h00, 0, 6'd0, bc);
    chk("R9 lock busy length", bc, WCYC);
    mdlLock = 1'b1;
    readAt(3'd2, 6'd5, rd); chk("R9 verify blocked", rd, 8'h00);
    for (int s = 8'h2F; s <= 8'h33; s++) begin
      readAt(3'd6, AW'(s), rd); chk("R8 signature", rd, expSig(AW'(s)));
    end
    readAt(3'd7, 6'h30, rd); chk("R10 spare mode output", rd, 8'h00);

    // full erase
    eraseOp(EMIN + 3, bc);
    chk("R7 erase busy length", bc, ECYC);
    for (int i = 0; i < DEPTH; i++) mdlMem[i] = 8'hFF;
    mdlLock = 1'b0;
    readAt(3'd2, 6'd5, rd);  chk("R7 erased and unlocked", rd, 8'hFF);
    readAt(3'd2, 6'd9, rd);  chk("R7 erased byte 9", rd, 8'hFF);

    // rewrite after erase, then lock 2
    strobeOp(3'd1, 1'b1, 6'd5, 8'h81, 0, 6'd0, bc);
    chk("R2 rewrite after erase", bc, WCYC);
    mdlMem[5] = 8'h81;
    readAt(3'd2, 6'd5, rd); chk("R2 rewrite readback", rd, 8'h81);
    strobeOp(3'd4, 1'b1, 6'd0, 8'h00, 0, 6'd0, bc);
    chk("R9 lock2 busy length", bc, WCYC);
    readAt(3'd2, 6'd5, rd); chk("R9 lock2 blocks verify", rd, 8'h00);
    readAt(3'd6, 6'h31, rd); chk("R8 signature under lock", rd, 8'h51);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule